// File: doc/BRIEF.md
# Deferred Clock-Multiplier Change Sequencer

This block decides when a new clock multiplication factor reaches the PLL. Software writes a target factor, a settling-time select, a divide-ratio select and, with each write, a flag that asks for the change to apply at once. Without that flag the target waits in a shadow register. The active code on `mult_code` only takes the shadow value when the block enters its standby halt, which is the point where the clock generator stops.

A wake-up request moves the block into a settling phase. That phase lasts 2^(SETTLE_BASE+select) reference cycles, and the select is captured at the moment of wake-up. The core clock is released only after the phase ends. While the block runs, a divider produces a half-rate or quarter-rate enable. A change to the divide ratio is taken up only at the boundary of a divider period, so no short enable period is ever produced. All logic runs on one free-running reference clock, and that clock keeps running through standby.

Top module: `clkmul_seq`

## Requirements
- R1: After reset the state is `mult_code`=0 (×1), `ready`=1, the divide ratio is ÷2 and the shadow target is 0.
- R2: A write with `wr_immediate`=0 stores `wr_factor` in the shadow register only. While the block runs, `mult_code` does not change.
- R3: When `standby_req` is 1 in the running state, the next cycle has `ready`=0 and `mult_code` equal to the shadow value held before that edge.
- R4: In the halt state the block stays halted until `wake_req`=1. During the halt, `clk_en`=0 and `mult_code` holds its value unless an immediate write arrives.
- R5: A `wake_req` accepted in the halt state starts settling. `ready` returns to 1 exactly 2^(SETTLE_BASE+S) clock edges after the accepting edge, where S is the 4-bit settle select held at that edge.
- R6: A write with `wr_immediate`=1 drives `mult_code` to `wr_factor` on the next cycle, in any state.
- R7: A deferred write made during settling updates the shadow register and leaves `mult_code` unchanged. The new value appears at the next standby entry.
- R8: `clk_en` pulses once every 2 cycles (when `wr_div4` was written 0) or once every 4 cycles (when it was written 1), and only while `ready`=1.
- R9: A new divide ratio takes effect only after the enable pulse that ends the current divider period. Every divider period therefore has the full length of a ratio.
- R10: A settle select written during settling does not change the length of the settling phase already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control fields |
| wr_factor | input | MUL_W | Target multiplication code |
| wr_settle | input | STS_W | Settling-time select S |
| wr_immediate | input | 1 | 1 = apply wr_factor at once |
| wr_div4 | input | 1 | Divide select: 0 = ÷2, 1 = ÷4 |
| standby_req | input | 1 | Request entry to standby halt |
| wake_req | input | 1 | Request to leave standby |
| mult_code | output | MUL_W | Active multiplier code to the PLL |
| ready | output | 1 | 1 while the core clock runs |
| clk_en | output | 1 | Divided clock enable pulse |

## Verification
The embedded properties are evaluated on every cycle. They cover the transfer of the shadow value on standby entry, the hold of `mult_code` whenever no immediate write arrives, the one-cycle response to an immediate write, and the rule that `clk_en` never fires outside the running state. The exact length of each settling phase, the independence of that length from a later write, and the pulse spacing across a ratio change involve counts over many cycles. Only the bench's reference model and its scenario checks can show these.

// File: rtl/clkmul_seq.sv
module clkmul_seq #(
  parameter int SETTLE_BASE = 8,
  parameter int STS_W       = 4,
  parameter int MUL_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [MUL_W-1:0] wr_factor,
  input  logic [STS_W-1:0] wr_settle,
  input  logic             wr_immediate,
  input  logic             wr_div4,
  input  logic             standby_req,
  input  logic             wake_req,
  output logic [MUL_W-1:0] mult_code,
  output logic             ready,
  output logic             clk_en
);
  localparam int CNT_W = SETTLE_BASE + (1 << STS_W) + 1;

  typedef enum logic [1:0] {S_RUN, S_HALT, S_SETTLE} st_t;

  st_t              st;
  logic [MUL_W-1:0] shadow, active;
  logic [STS_W-1:0] sts_q;
  logic             div4_q, ratio4;
  logic [CNT_W-1:0] cnt, lim;
  logic [1:0]       ph;
  logic             ph_last;

  assign ready     = (st == S_RUN);
  assign mult_code = active;
  assign ph_last   = ratio4 ? (ph == 2'd3) : (ph == 2'd1);
  assign clk_en    = ready && ph_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      sts_q  <= '0;
      div4_q <= 1'b0;
    end else if (wr_en) begin
      shadow <= wr_factor;
      sts_q  <= wr_settle;
      div4_q <= wr_div4;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) active <= '0;
    else if (wr_en && wr_immediate) active <= wr_factor;
    else if (st == S_RUN && standby_req) active <= shadow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_RUN;
      cnt <= '0;
      lim <= '0;
    end else begin
      case (st)
        S_RUN:  if (standby_req) st <= S_HALT;
        S_HALT: if (wake_req) begin
          st  <= S_SETTLE;
          cnt <= '0;
          lim <= (CNT_W'(1) << (SETTLE_BASE + int'(sts_q))) - CNT_W'(1);
        end
        S_SETTLE: begin
          if (cnt == lim) st <= S_RUN;
          else cnt <= cnt + CNT_W'(1);
        end
        default: st <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= '0;
      ratio4 <= 1'b0;
    end else if (st != S_RUN || ph_last) begin
      ph     <= '0;
      ratio4 <= div4_q;
    end else begin
      ph <= ph + 2'd1;
    end
  end

  // R3
  standby_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && standby_req && !(wr_en && wr_immediate)) |=> (!ready && mult_code == $past(shadow)));

  // R2
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !standby_req && !(wr_en && wr_immediate)) |=> $stable(mult_code));

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !(wr_en && wr_immediate)) |=> $stable(mult_code));

  // R6
  imm_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_immediate) |=> (mult_code == $past(wr_factor)));

  // R8
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> ready);

  // R4
  halt_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HALT && !wake_req) |=> (st == S_HALT));
endmodule

// File: tb/test_clkmul_seq.sv
module test_clkmul_seq;
  localparam int BASE = 2;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_immediate = 0, wr_div4 = 0, standby_req = 0, wake_req = 0;
  logic [1:0] wr_factor = 0;
  logic [3:0] wr_settle = 0;
  logic [1:0] mult_code;
  logic ready, clk_en;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  clkmul_seq #(.SETTLE_BASE(BASE)) i_clkmul_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_factor(wr_factor),
    .wr_settle(wr_settle), .wr_immediate(wr_immediate), .wr_div4(wr_div4),
    .standby_req(standby_req), .wake_req(wake_req),
    .mult_code(mult_code), .ready(ready), .clk_en(clk_en));

  // reference model: 0 run, 1 halt, 2 settle
  int m_st, m_mult, m_shadow, m_sts, m_div4, m_cnt, m_len, m_ph, m_ratio;

  always @(posedge clk) begin
    int n_st, n_mult, n_cnt, n_len, n_ph, n_ratio;
    if (!rst_n) begin
      m_st = 0; m_mult = 0; m_shadow = 0; m_sts = 0; m_div4 = 0;
      m_cnt = 0; m_len = 0; m_ph = 0; m_ratio = 2;
    end else begin
      n_st = m_st; n_mult = m_mult; n_cnt = m_cnt; n_len = m_len;
      if (m_st == 0 && standby_req) begin n_st = 1; n_mult = m_shadow; end
      else if (m_st == 1 && wake_req) begin n_st = 2; n_cnt = 1; n_len = 1 << (BASE + m_sts); end
      else if (m_st == 2) begin
        if (m_cnt >= m_len) n_st = 0; else n_cnt = m_cnt + 1;
      end
      if (m_st == 0 && m_ph != m_ratio - 1) begin n_ph = m_ph + 1; n_ratio = m_ratio; end
      else begin n_ph = 0; n_ratio = m_div4 ? 4 : 2; end
      if (wr_en) begin
        if (wr_immediate) n_mult = wr_factor;
        m_shadow = wr_factor; m_sts = wr_settle; m_div4 = wr_div4;
      end
      m_st = n_st; m_mult = n_mult; m_cnt = n_cnt; m_len = n_len;
      m_ph = n_ph; m_ratio = n_ratio;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 R3 R6 R7 mult_code vs model", mult_code, m_mult);
    chk("R4 R5 ready vs model", ready, m_st == 0);
    chk("R8 R9 clk_en vs model", clk_en, (m_st == 0) && (m_ph == m_ratio - 1));
  end

  task automatic wr(input logic [1:0] f, input logic [3:0] s, input logic imm, input logic d4);
    wr_en = 1; wr_factor = f; wr_settle = s; wr_immediate = imm; wr_div4 = d4;
    @(negedge clk);
    wr_en = 0; wr_immediate = 0;
  endtask

  task automatic pulse_standby();
    standby_req = 1; @(negedge clk); standby_req = 0;
  endtask

  task automatic wake_and_count(output int n);
    wake_req = 1; @(negedge clk); wake_req = 0;
    n = 0;
    while (!ready && n < 5000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic count_pulses(input int cycles, output int p);
    p = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk); if (clk_en) p++;
    end
  endtask

  initial begin
    #200000;
    failures++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n, p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mult_code after reset", mult_code, 0);
    chk("R1 ready after reset", ready, 1);
    count_pulses(8, p);
    chk("R8 R1 div2 pulses in 8 cycles", p, 4);

    wr(2'd2, 4'd0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    chk("R2 deferred write holds mult_code", mult_code, 0);

    pulse_standby();
    chk("R3 ready drops on standby", ready, 0);
    chk("R3 shadow copied on standby", mult_code, 2);
    count_pulses(6, p);
    chk("R4 no clk_en in halt", p, 0);
    chk("R4 still halted without wake", ready, 0);
    wake_and_count(n);
    chk("R5 settle length S=0", n, 1 << BASE);

    wr(2'd3, 4'd0, 1'b1, 1'b0);
    chk("R6 immediate write applied", mult_code, 3);

    wr(2'd1, 4'd3, 1'b0, 1'b0);
    pulse_standby();
    chk("R3 second standby copy", mult_code, 1);
    wake_req = 1; @(negedge clk); wake_req = 0;
    repeat (3) @(negedge clk);
    wr(2'd0, 4'd0, 1'b0, 1'b0);
    n = 4;
    while (!ready && n < 5000) begin @(negedge clk); n++; end
    chk("R10 settle length kept at S=3", n, 1 << (BASE + 3));
    chk("R7 settle-phase write deferred", mult_code, 1);
    repeat (3) @(negedge clk);
    pulse_standby();
    chk("R7 shadow applied at next standby", mult_code, 0);
    wake_and_count(n);
    chk("R5 settle length after rewrite S=0", n, 1 << BASE);

    @(negedge clk);
    wr(2'd0, 4'd0, 1'b0, 1'b1);
    repeat (6) @(negedge clk);
    count_pulses(16, p);
    chk("R9 R8 div4 pulses in 16 cycles", p, 4);

    wr(2'd2, 4'd0, 1'b1, 1'b1);
    pulse_standby();
    chk("R6 R3 imm then standby", mult_code, 2);
    count_pulses(4, p);
    chk("R4 halt quiet after imm", p, 0);
    wr(2'd1, 4'd0, 1'b1, 1'b1);
    chk("R6 immediate write in halt", mult_code, 1);
    wake_and_count(n);
    chk("R5 settle after halt write", n, 1 << BASE);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule